// File: doc/BRIEF.md
# Dual-Function Parallel Port Controller

This block controls nine device pins. Each pin works either as a general-purpose I/O line under software control or as a line that belongs to an on-chip serial peripheral. Three word registers on a simple register bus set it up. A function-select register picks the owner of each pin. A direction register sets the pin's output enable while software owns it. A data register holds the output levels, and a read of it returns the pin levels.

While a pin is in peripheral mode, the peripheral's output value and enable go straight to the pad, and the synchronized pad level is forwarded to the peripheral. While a pin is in GPIO mode, the direction and data registers drive the pad, and the peripheral input for that pin is held low. Every pad input passes through a two-flop synchronizer before it is used.

Top module: `dual_port_ctrl`

## Requirements
- R1: After reset the function-select, direction and output registers are all zero. All pins are GPIO inputs: pad_oe_o = 0, pad_o = 0 and per_in_o = 0.
- R2: A bus write (bus_sel_i=1, bus_we_i=1) to address 0xFFE1 loads the function-select register from bus_wdata_i[8:0]. Bit i = 1 gives pin i to the peripheral and bit i = 0 keeps it GPIO. A read of that address returns the register.
- R3: A bus write to 0xFFE3 loads the direction register from bus_wdata_i[8:0]. A GPIO pin drives pad_oe_o[i] from direction bit i (1 = output, 0 = input). The register reads back at 0xFFE3.
- R4: A bus write to 0xFFE5 loads the output register. A GPIO pin drives pad_o[i] from output bit i, starting the cycle after the write.
- R5: For a pin in peripheral mode, pad_o[i] follows per_out_i[i] and pad_oe_o[i] follows per_oe_i[i] in the same cycle, whatever the direction and output registers hold.
- R6: A change on pad_i reaches per_in_o on the second rising clock edge after it, for peripheral-mode pins only. per_in_o[i] is 0 for GPIO pins.
- R7: A read of 0xFFE5 returns the synchronized level of all nine pins in bits [8:0], whatever each pin's mode or direction.
- R8: Write-data bits above bit 8 are discarded. The upper bits of every read are zero. A write to any other address changes no register and no pin output.
- R9: Read data appears on bus_rdata_o one cycle after the read request. It holds until the next read request. A read of an unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 16 | Word address |
| bus_wdata_i | input | 24 | Write data |
| bus_rdata_o | output | 24 | Registered read data |
| pad_i | input | 9 | Pad input levels |
| pad_o | output | 9 | Pad output levels |
| pad_oe_o | output | 9 | Pad output enables |
| per_out_i | input | 9 | Peripheral output values |
| per_oe_i | input | 9 | Peripheral output enables |
| per_in_o | output | 9 | Synchronized pad levels forwarded to the peripheral |

## Verification
Register writes take effect at the next rising edge. Pad outputs and output enables are combinational from the registers, so they are checked half a cycle after that edge. Peripheral-mode outputs are combinational from the peripheral inputs and are checked in the cycle they are driven. A pad input is checked one edge after it changes, when it must not yet have reached per_in_o, and again two edges after, when it must have arrived. Before any data-register read, the bench waits more than three edges after the pad changes, so the read returns the new pad level. Read results are queued when the request is issued and popped 1 ns after the edge that registers them.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_FUNC = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ppc_sync.sv
module ppc_sync #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;
  logic [1:0]   warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      warm_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
  end

  assign q_o = sync_q;

  assert_sync_delay_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/ppc_regs.sv
module ppc_regs
  import ppc_pkg::*;
#(
  parameter int          NPINS     = 9,
  parameter int          AW        = 16,
  parameter int          DW        = 24,
  parameter logic [15:0] FUNC_ADDR = 16'hFFE1,
  parameter logic [15:0] DIR_ADDR  = 16'hFFE3,
  parameter logic [15:0] DATA_ADDR = 16'hFFE5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [NPINS-1:0] pin_lvl_i,
  output logic [NPINS-1:0] func_o,
  output logic [NPINS-1:0] dir_o,
  output logic [NPINS-1:0] out_o
);
  localparam int PAD = DW - NPINS;

  reg_sel_e            dec;
  logic [NPINS-1:0]    func_q, dir_q, out_q;
  logic [NPINS-1:0]    rd_mux;
  logic [DW-1:0]       rdata_q;

  always_comb begin
    if (addr_i == AW'(FUNC_ADDR))      dec = SEL_FUNC;
    else if (addr_i == AW'(DIR_ADDR))  dec = SEL_DIR;
    else if (addr_i == AW'(DATA_ADDR)) dec = SEL_DATA;
    else                               dec = SEL_NONE;
  end

  always_comb begin
    unique case (dec)
      SEL_FUNC: rd_mux = func_q;
      SEL_DIR:  rd_mux = dir_q;
      SEL_DATA: rd_mux = pin_lvl_i;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      func_q  <= '0;
      dir_q   <= '0;
      out_q   <= '0;
      rdata_q <= '0;
    end else if (sel_i) begin
      if (we_i) begin
        if (dec == SEL_FUNC) func_q <= wdata_i[NPINS-1:0];
        if (dec == SEL_DIR)  dir_q  <= wdata_i[NPINS-1:0];
        if (dec == SEL_DATA) out_q  <= wdata_i[NPINS-1:0];
      end else begin
        rdata_q <= {{PAD{1'b0}}, rd_mux};
      end
    end
  end

  assign rdata_o = rdata_q;
  assign func_o  = func_q;
  assign dir_o   = dir_q;
  assign out_o   = out_q;

  assert_func_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr_i == AW'(FUNC_ADDR)) |=> (func_o == $past(wdata_i[NPINS-1:0])));

  assert_unmapped_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && dec == SEL_NONE) |=> ($stable(func_o) && $stable(dir_o) && $stable(out_o)));

  assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && !we_i) |=> $stable(rdata_o));
endmodule

// File: rtl/ppc_pin_cell.sv
module ppc_pin_cell (
  input  logic func_i,
  input  logic dir_i,
  input  logic out_i,
  input  logic lvl_i,
  input  logic per_out_i,
  input  logic per_oe_i,
  output logic pad_o,
  output logic pad_oe_o,
  output logic per_in_o
);
  // func_i = 1: peripheral owns the pin
  assign pad_o    = func_i ? per_out_i : out_i;
  assign pad_oe_o = func_i ? per_oe_i  : dir_i;
  assign per_in_o = func_i & lvl_i;
endmodule

// File: rtl/dual_port_ctrl.sv
module dual_port_ctrl #(
  parameter int NPINS = 9,
  parameter int AW    = 16,
  parameter int DW    = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_sel_i,
  input  logic             bus_we_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  input  logic [NPINS-1:0] pad_i,
  output logic [NPINS-1:0] pad_o,
  output logic [NPINS-1:0] pad_oe_o,
  input  logic [NPINS-1:0] per_out_i,
  input  logic [NPINS-1:0] per_oe_i,
  output logic [NPINS-1:0] per_in_o
);
  logic [NPINS-1:0] lvl, func, dir, outr;

  ppc_sync #(.W(NPINS)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pad_i), .q_o(lvl)
  );

  ppc_regs #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sel_i(bus_sel_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .pin_lvl_i(lvl), .func_o(func), .dir_o(dir), .out_o(outr)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    ppc_pin_cell u_cell (
      .func_i(func[i]), .dir_i(dir[i]), .out_i(outr[i]), .lvl_i(lvl[i]),
      .per_out_i(per_out_i[i]), .per_oe_i(per_oe_i[i]),
      .pad_o(pad_o[i]), .pad_oe_o(pad_oe_o[i]), .per_in_o(per_in_o[i])
    );
  end

  assert_per_owns_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_o & func) == (per_out_i & func)) && ((pad_oe_o & func) == (per_oe_i & func)));

  assert_gpio_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_in_o & ~func) == '0);
endmodule

// File: tb/sim_dual_port_ctrl.sv
module sim_dual_port_ctrl;
  localparam logic [15:0] A_FUNC = 16'hFFE1;
  localparam logic [15:0] A_DIR  = 16'hFFE3;
  localparam logic [15:0] A_DATA = 16'hFFE5;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        sel = 0, we = 0;
  logic [15:0] addr = '0;
  logic [23:0] wdata = '0;
  logic [23:0] rdata;
  logic [8:0]  pad_in = '0, pad_out, pad_oe, per_out = '0, per_oe = '0, per_in;

  int checks = 0, fails = 0;
  logic [23:0] exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  always #2 clk = ~clk;

  dual_port_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pad_i(pad_in), .pad_o(pad_out), .pad_oe_o(pad_oe),
    .per_out_i(per_out), .per_oe_i(per_oe), .per_in_o(per_in)
  );

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [15:0] a, logic [23:0] d);
    @(negedge clk);
    sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; we = 0;
  endtask

  // driver: queue expected read data, monitor compares
  task automatic bus_rd(logic [15:0] a, logic [23:0] exp, string req);
    @(negedge clk);
    sel = 1; we = 0; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    sel = 0;
  endtask

  always @(posedge clk) begin
    automatic bit req = sel && !we;
    #1;
    if (req && exp_q.size() > 0) chk(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    // R1: reset state
    chk("R1 oe", 24'(pad_oe), 24'h0);
    chk("R1 out", 24'(pad_out), 24'h0);
    chk("R1 per_in", 24'(per_in), 24'h0);
    bus_rd(A_FUNC, 24'h0, "R1 func");
    bus_rd(A_DIR, 24'h0, "R1 dir");

    // R3, R4: GPIO drive
    bus_wr(A_DIR, 24'h0001FF);
    bus_wr(A_DATA, 24'h0000A5);
    chk("R3 oe", 24'(pad_oe), 24'h1FF);
    chk("R4 out", 24'(pad_out), 24'h0A5);
    bus_rd(A_DIR, 24'h1FF, "R3 readback");

    // R2, R8: func select with junk upper bits
    bus_wr(A_FUNC, 24'hFFF0F0);
    bus_rd(A_FUNC, 24'h0000F0, "R2/R8 func readback");

    // R5: peripheral outputs on pins 4..7
    @(negedge clk);
    per_out = 9'h155; per_oe = 9'h0C3;
    #1;
    chk("R5 out", 24'(pad_out), 24'h055);
    chk("R5 oe", 24'(pad_oe), 24'h1CF);

    // R6: two-edge synchronizer, GPIO pins masked
    @(negedge clk);
    pad_in = 9'h1A3;
    @(negedge clk);
    chk("R6 one edge", 24'(per_in), 24'h0);
    @(negedge clk);
    chk("R6 two edges", 24'(per_in), 24'h0A0);

    // R7: data read returns all pins regardless of mode/direction
    idle(2);
    bus_rd(A_DATA, 24'h0001A3, "R7 mixed");
    bus_wr(A_DIR, 24'h0);
    bus_rd(A_DATA, 24'h0001A3, "R7 all inputs");
    chk("R3 oe after dir clear", 24'(pad_oe), 24'h0C0);

    // R8: unmapped write ignored
    bus_wr(16'hFFE2, 24'hFFFFFF);
    chk("R8 out unchanged", 24'(pad_out), 24'h055);
    chk("R8 oe unchanged", 24'(pad_oe), 24'h0C0);
    bus_rd(A_FUNC, 24'h0F0, "R8 func unchanged");
    bus_rd(A_DIR, 24'h000, "R8 dir unchanged");

    // R9: hold and unmapped read
    bus_rd(A_FUNC, 24'h0F0, "R9 read");
    idle(3);
    chk("R9 hold", rdata, 24'h0F0);
    bus_rd(16'h1234, 24'h0, "R9 unmapped");

    // R4: back to GPIO on all pins
    bus_wr(A_FUNC, 24'h0);
    bus_wr(A_DATA, 24'h00015A);
    chk("R4 gpio out", 24'(pad_out), 24'h15A);
    chk("R6 gpio per_in", 24'(per_in), 24'h0);

    idle(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule